// File: doc/BRIEF.md
# Occupancy-Driven PI Frequency Controller

This block sets the clock frequency of one clock domain that exchanges data with neighbouring domains through queues. A free-running interval timer marks the end of each sampling interval. At that instant the block takes the averaged fill level of the domain's input queue and the domain's measured instructions-per-cycle. It advances a proportional-integral control state from the occupancy error and from the change in occupancy since the last interval. It then divides that state by the measured IPC to obtain the new frequency code.

All quantities are fixed point with `FRAC` fractional bits. Occupancy, IPC, the control state and the frequency code are unsigned. The two gains are signed. The control state and the published frequency are both held between a minimum code and a maximum code. The division runs on a sequential divider over several cycles. Each new code is offered on a valid/ready output handshake. A zero IPC skips the divider and publishes the maximum code.

Top module: `occ_pi_freq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `freq_valid` is 0 and `freq_code` equals `MU_INIT`. The control state starts at `MU_INIT` and the previous-occupancy register starts at `Q_REF`.
- R2: The block makes exactly one update every `INTERVAL` clock cycles. Two successive results that both come from the divider are therefore published exactly `INTERVAL` cycles apart.
- R3: At each update the control state becomes mu + floor(KI*(q - Q_REF)/2^FRAC) + floor(KP*(q - q_prev)/2^FRAC). Here q is the occupancy sampled at this update and q_prev is the occupancy sampled at the previous update, or `Q_REF` for the first update after reset.
- R4: The updated control state is limited to the range [`F_MIN`, `F_MAX`] before it is stored and before it is used.
- R5: For a nonzero IPC, the published code is floor(mu*2^FRAC / ipc), limited to [`F_MIN`, `F_MAX`]. An ipc of 2^FRAC (1.0) therefore publishes mu unchanged.
- R6: An IPC of zero at the update publishes `F_MAX` in the cycle after the update, without using the divider.
- R7: Once `freq_valid` is 1, it stays 1 and `freq_code` stays stable until a cycle in which `freq_ready` is 1. `freq_valid` is 0 after that cycle unless a new result arrives in it.
- R8: If a result has not been accepted when the next result arrives, the new code replaces the old one and `freq_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_avg | input | Q_W | Averaged input-queue occupancy, unsigned, FRAC fractional bits |
| ipc | input | IPC_W | Measured instructions per cycle, unsigned, FRAC fractional bits |
| freq_code | output | F_W | Published frequency code, unsigned, FRAC fractional bits |
| freq_valid | output | 1 | A published code is waiting to be accepted |
| freq_ready | input | 1 | Consumer accepts the code in this cycle |

## Verification
The cases that are hardest to reach from the ports are the saturation corners. These are a control state driven into either limit, and a quotient that exceeds `F_MAX` or falls below `F_MIN`. Each needs a particular history of occupancy samples rather than one input value. The stimulus first makes full-queue and empty-queue runs of several intervals to pin the state at each limit. Near those limits it pairs very small and very large IPC values with occasional zero IPC. Random intervals then follow, and a bench model carries the state from one interval to the next. One directed interval leaves a result unaccepted, so that the next update replaces it.

// File: rtl/pifc_pkg.sv
package pifc_pkg;
   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;
endpackage

// File: rtl/pifc_interval_timer.sv
module pifc_interval_timer #(
   parameter int INTERVAL = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = $clog2(INTERVAL);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   initial begin
      assert (INTERVAL >= 4) else $error("INTERVAL too small");
   end

   assign last = (cnt_q == CNT_W'(INTERVAL - 1));
   assign tick = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (last) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   // R2: updates are separated by at least one idle cycle
   a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pifc_pi_state.sv
module pifc_pi_state #(
   parameter int Q_W    = 16,
   parameter int F_W    = 16,
   parameter int GAIN_W = 16,
   parameter int FRAC   = 8,
   parameter logic [Q_W-1:0]           Q_REF   = 16'h0800,
   parameter logic signed [GAIN_W-1:0] KI      = 16'sh0040,
   parameter logic signed [GAIN_W-1:0] KP      = 16'sh0080,
   parameter logic [F_W-1:0]           MU_INIT = 16'h0800,
   parameter logic [F_W-1:0]           F_MIN   = 16'h0100,
   parameter logic [F_W-1:0]           F_MAX   = 16'h2000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           update,
   input  logic [Q_W-1:0] occ,
   output logic [F_W-1:0] mu_next,
   output logic [F_W-1:0] mu_cur
);
   localparam int DIFF_W = Q_W + 1;
   localparam int PROD_W = GAIN_W + DIFF_W;
   localparam int SUM_W  = PROD_W + 2;

   logic [F_W-1:0]           mu_q;
   logic [Q_W-1:0]           qprev_q;
   logic signed [DIFF_W-1:0] err, dq;
   logic signed [PROD_W-1:0] ki_x, kp_x, err_x, dq_x, prod_i, prod_p;
   logic signed [SUM_W-1:0]  ext_i, ext_p, term_i, term_p, mu_x, sum, lo_x, hi_x;

   initial begin
      assert (F_MIN <= F_MAX) else $error("F_MIN above F_MAX");
      assert (MU_INIT >= F_MIN && MU_INIT <= F_MAX) else $error("MU_INIT out of range");
      assert (F_W < SUM_W - 1) else $error("sum width too small");
      assert (FRAC < PROD_W) else $error("FRAC too large");
   end

   assign err = $signed({1'b0, occ}) - $signed({1'b0, Q_REF});
   assign dq  = $signed({1'b0, occ}) - $signed({1'b0, qprev_q});

   assign ki_x  = {{DIFF_W{KI[GAIN_W-1]}}, KI};
   assign kp_x  = {{DIFF_W{KP[GAIN_W-1]}}, KP};
   assign err_x = {{GAIN_W{err[DIFF_W-1]}}, err};
   assign dq_x  = {{GAIN_W{dq[DIFF_W-1]}}, dq};

   assign prod_i = ki_x * err_x;
   assign prod_p = kp_x * dq_x;

   assign ext_i  = {{2{prod_i[PROD_W-1]}}, prod_i};
   assign ext_p  = {{2{prod_p[PROD_W-1]}}, prod_p};
   assign term_i = ext_i >>> FRAC;
   assign term_p = ext_p >>> FRAC;

   assign mu_x = {{(SUM_W-F_W){1'b0}}, mu_q};
   assign lo_x = {{(SUM_W-F_W){1'b0}}, F_MIN};
   assign hi_x = {{(SUM_W-F_W){1'b0}}, F_MAX};
   assign sum  = mu_x + term_i + term_p;

   always_comb begin
      if (sum < lo_x)      mu_next = F_MIN;
      else if (sum > hi_x) mu_next = F_MAX;
      else                 mu_next = sum[F_W-1:0];
   end

   assign mu_cur = mu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mu_q    <= MU_INIT;
         qprev_q <= Q_REF;
      end else if (update) begin
         mu_q    <= mu_next;
         qprev_q <= occ;
      end
   end

   // R4: the stored control state never leaves the code range
   a_r4_mu_range: assert property (@(posedge clk) disable iff (!rst_n)
      (mu_q >= F_MIN) && (mu_q <= F_MAX));
   // R3: the previous-occupancy register follows the sample taken at an update
   a_r3_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> (qprev_q == $past(occ)));
   // R3: between updates the control state holds
   a_r3_mu_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(mu_q));
endmodule

// File: rtl/pifc_seq_divider.sv
module pifc_seq_divider
   import pifc_pkg::*;
#(
   parameter int DD_W = 24,
   parameter int DV_W = 16,
   parameter int BPS  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [DD_W-1:0] dividend,
   input  logic [DV_W-1:0] divisor,
   output logic            busy,
   output logic            done,
   output logic [DD_W-1:0] quotient
);
   localparam int STEPS = DD_W / BPS;
   localparam int CNT_W = $clog2(STEPS + 1);

   div_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DV_W-1:0]  rem_q, dvs_q;
   logic [DD_W-1:0]  dvd_q, quo_q;
   logic             done_q;

   logic [DV_W-1:0] st_rem [BPS+1];
   logic [DD_W-1:0] st_dvd [BPS+1];
   logic [DD_W-1:0] st_quo [BPS+1];

   initial begin
      assert (BPS >= 1 && (DD_W % BPS) == 0) else $error("BPS must divide DD_W");
      assert (STEPS >= 2) else $error("divider needs at least two steps");
   end

   assign st_rem[0] = rem_q;
   assign st_dvd[0] = dvd_q;
   assign st_quo[0] = quo_q;

   for (genvar s = 0; s < BPS; s++) begin : g_step
      logic [DV_W:0] trial, diff;
      logic          take;
      assign trial = {st_rem[s], st_dvd[s][DD_W-1]};
      assign take  = (trial >= {1'b0, dvs_q});
      assign diff  = trial - {1'b0, dvs_q};
      assign st_rem[s+1] = take ? diff[DV_W-1:0] : trial[DV_W-1:0];
      assign st_dvd[s+1] = {st_dvd[s][DD_W-2:0], 1'b0};
      assign st_quo[s+1] = {st_quo[s][DD_W-2:0], take};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DIV_IDLE;
         cnt_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         dvd_q  <= '0;
         quo_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            DIV_IDLE: begin
               if (start) begin
                  st_q  <= DIV_RUN;
                  cnt_q <= '0;
                  rem_q <= '0;
                  dvs_q <= divisor;
                  dvd_q <= dividend;
                  quo_q <= '0;
               end
            end
            default: begin
               rem_q <= st_rem[BPS];
               dvd_q <= st_dvd[BPS];
               quo_q <= st_quo[BPS];
               if (cnt_q == CNT_W'(STEPS - 1)) begin
                  st_q   <= DIV_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy     = (st_q == DIV_RUN);
   assign done     = done_q;
   assign quotient = quo_q;

   // R5: a division is never restarted while one is running
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R5: completion is a single-cycle pulse following a running division
   a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
endmodule

// File: rtl/occ_pi_freq_ctrl.sv
module occ_pi_freq_ctrl #(
   parameter int Q_W      = 16,
   parameter int IPC_W    = 16,
   parameter int F_W      = 16,
   parameter int GAIN_W   = 16,
   parameter int FRAC     = 8,
   parameter int INTERVAL = 64,
   parameter int BPS      = 1,
   parameter logic [Q_W-1:0]           Q_REF   = 16'h0800,
   parameter logic signed [GAIN_W-1:0] KI      = 16'sh0040,
   parameter logic signed [GAIN_W-1:0] KP      = 16'sh0080,
   parameter logic [F_W-1:0]           MU_INIT = 16'h0800,
   parameter logic [F_W-1:0]           F_MIN   = 16'h0100,
   parameter logic [F_W-1:0]           F_MAX   = 16'h2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [Q_W-1:0]   occ_avg,
   input  logic [IPC_W-1:0] ipc,
   output logic [F_W-1:0]   freq_code,
   output logic             freq_valid,
   input  logic             freq_ready
);
   localparam int DD_W  = F_W + FRAC;
   localparam int STEPS = DD_W / BPS;

   logic            tick, div_busy, div_done, zero_ipc, bypass_load, div_start, load;
   logic [F_W-1:0]  mu_next, mu_cur, quo_clamped, load_code;
   logic [DD_W-1:0] quotient;
   logic [F_W-1:0]  code_q;
   logic            valid_q;

   initial begin
      assert (INTERVAL > STEPS + 3) else $error("INTERVAL shorter than a division");
   end

   pifc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   pifc_pi_state #(
      .Q_W(Q_W), .F_W(F_W), .GAIN_W(GAIN_W), .FRAC(FRAC),
      .Q_REF(Q_REF), .KI(KI), .KP(KP), .MU_INIT(MU_INIT),
      .F_MIN(F_MIN), .F_MAX(F_MAX)
   ) u_pi (
      .clk    (clk),
      .rst_n  (rst_n),
      .update (tick),
      .occ    (occ_avg),
      .mu_next(mu_next),
      .mu_cur (mu_cur)
   );

   assign zero_ipc    = (ipc == '0);
   assign bypass_load = tick && zero_ipc;
   assign div_start   = tick && !zero_ipc;

   pifc_seq_divider #(.DD_W(DD_W), .DV_W(IPC_W), .BPS(BPS)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (div_start),
      .dividend({mu_next, {FRAC{1'b0}}}),
      .divisor (ipc),
      .busy    (div_busy),
      .done    (div_done),
      .quotient(quotient)
   );

   always_comb begin
      if (quotient > {{FRAC{1'b0}}, F_MAX})      quo_clamped = F_MAX;
      else if (quotient < {{FRAC{1'b0}}, F_MIN}) quo_clamped = F_MIN;
      else                                       quo_clamped = quotient[F_W-1:0];
   end

   assign load      = bypass_load || div_done;
   assign load_code = bypass_load ? F_MAX : quo_clamped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= MU_INIT;
         valid_q <= 1'b0;
      end else if (load) begin
         code_q  <= load_code;
         valid_q <= 1'b1;
      end else if (freq_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign freq_code  = code_q;
   assign freq_valid = valid_q;

   // R6: zero IPC publishes the maximum code on the next cycle
   a_r6_zero_ipc_max: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (ipc == '0)) |=> (freq_valid && (freq_code == F_MAX)));
   // R7: an unaccepted code stays offered
   a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_valid && !freq_ready) |=> freq_valid);
   // R7: the offered code is stable until accepted or replaced
   a_r7_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_valid && !freq_ready && !load) |=> $stable(freq_code));
   // R5: a published code always lies inside the code range
   a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |-> ((freq_code >= F_MIN) && (freq_code <= F_MAX)));
   // R8: a new result keeps the output valid
   a_r8_replace_valid: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |=> freq_valid);
   // R2: no update arrives while a division is in flight
   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !tick);
endmodule

// File: tb/occ_pi_freq_ctrl_tb.sv
module occ_pi_freq_ctrl_tb;
   localparam int  INTERVAL = 64;
   localparam int  FRAC     = 8;
   localparam longint Q_REF   = 'h0800;
   localparam longint KI      = 'h0040;
   localparam longint KP      = 'h0080;
   localparam longint MU_INIT = 'h0800;
   localparam longint F_MIN   = 'h0100;
   localparam longint F_MAX   = 'h2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] occ_avg = 16'h0900;
   logic [15:0] ipc = 16'h0100;
   logic [15:0] freq_code;
   logic        freq_valid;
   logic        freq_ready = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   longint m_mu = MU_INIT;
   longint m_qprev = Q_REF;
   int  last_rise = -1;
   bit  last_div = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   occ_pi_freq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .occ_avg(occ_avg), .ipc(ipc),
      .freq_code(freq_code), .freq_valid(freq_valid), .freq_ready(freq_ready)
   );

   function automatic longint clampv(input longint v);
      if (v < F_MIN) return F_MIN;
      if (v > F_MAX) return F_MAX;
      return v;
   endfunction

   function automatic longint model_step(input longint q, input longint ip);
      longint ti, tp;
      ti = (KI * (q - Q_REF)) >>> FRAC;
      tp = (KP * (q - m_qprev)) >>> FRAC;
      m_mu = clampv(m_mu + ti + tp);
      m_qprev = q;
      if (ip == 0) return F_MAX;
      return clampv((m_mu << FRAC) / ip);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act %0h exp %0h", req, act, exp);
      end
   endtask

   task automatic run_interval(input logic [15:0] q, input logic [15:0] ip,
                               input int hold, input string req);
      longint e;
      occ_avg = q;
      ipc = ip;
      e = model_step(q, ip);
      while (!freq_valid) @(negedge clk);
      check(freq_code == e[15:0], req, freq_code, e);
      if (ip != 0 && last_div && last_rise >= 0)
         check(cyc - last_rise == INTERVAL, "R2 interval", cyc - last_rise, INTERVAL);
      last_rise = cyc;
      last_div  = (ip != 0);
      if (hold > 0) begin
         repeat (hold) @(negedge clk);
         check(freq_valid && freq_code == e[15:0], "R7 hold", freq_code, e);
      end
      freq_ready = 1'b1;
      @(negedge clk);
      freq_ready = 1'b0;
      check(!freq_valid, "R7 clear", freq_valid, 0);
   endtask

   initial begin
      repeat (INTERVAL * 2500) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R2 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      longint e1, e2;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check(!freq_valid && freq_code == MU_INIT[15:0], "R1 reset", freq_code, MU_INIT);
      rst_n = 1'b1;
      @(negedge clk);
      check(!freq_valid && freq_code == MU_INIT[15:0], "R1 after reset", freq_code, MU_INIT);

      // R3 first update uses Q_REF as previous occupancy; ipc 1.0 exposes mu
      run_interval(16'h0900, 16'h0100, 2, "R3 first update");
      run_interval(16'h0700, 16'h0100, 0, "R3 falling occupancy");
      run_interval(16'h0a80, 16'h0180, 1, "R5 ipc 1.5");
      // R4 drive state to the upper limit
      run_interval(16'hff00, 16'h0100, 0, "R4 upper clamp");
      run_interval(16'hff00, 16'h0040, 0, "R5 quotient above max");
      run_interval(16'hff00, 16'h0000, 3, "R6 zero ipc");
      // R4 drive state to the lower limit
      run_interval(16'h0000, 16'h0100, 0, "R4 lower clamp");
      run_interval(16'h0000, 16'hffff, 0, "R5 quotient below min");
      run_interval(16'h0800, 16'h0100, 0, "R3 back at reference");

      // R8 leave one result unaccepted; the next one replaces it
      occ_avg = 16'h0c00;
      ipc = 16'h0100;
      e1 = model_step(16'h0c00, 16'h0100);
      while (!freq_valid) @(negedge clk);
      check(freq_code == e1[15:0], "R8 first result", freq_code, e1);
      occ_avg = 16'h0400;
      ipc = 16'h0200;
      e2 = model_step(16'h0400, 16'h0200);
      repeat (INTERVAL) @(negedge clk);
      check(freq_valid && freq_code == e2[15:0], "R8 replaced", freq_code, e2);
      freq_ready = 1'b1;
      @(negedge clk);
      freq_ready = 1'b0;
      last_div = 1'b0;

      for (int i = 0; i < 120; i++) begin
         logic [15:0] rq, ri;
         rq = 16'($urandom_range(0, 16'h1800));
         ri = ($urandom_range(0, 9) == 0) ? 16'h0000 : 16'($urandom_range(1, 16'h0400));
         run_interval(rq, ri, int'($urandom_range(0, 4)),
                      (ri == 0) ? "R6 random" : "R5 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule